// File: doc/BRIEF.md
# Gain-Loop Sync Hold-Off Timer

This block sits in front of a gain-control loop and decides when that loop takes a new measurement. A pin sync or a software sync starts a programmable hold-off delay. When the delay runs out, the block sends a one-cycle update strobe. The update strobe tells the loop to emit a new averaged sample and to restart its decimation toward the next one. An initialize strobe can go with the update strobe. It tells the loop to clear its filter state and to load fresh parameters.

The hold-off value sets the delay. Zero turns the external sync path off. One fires on the same event, with no delay. Any larger value N fires N-1 clock edges after the edge that captured the event. A first-only mode lets a system that pulses its sync line periodically align the loop once and then leave it free-running. A sync-now control forces an update directly, without waiting for the external inputs. The block contains only the countdown and the masking logic. Configuration arrives on level ports, and a one-cycle write strobe marks a rewrite of the first-only setting.

Top module: `gain_sync_timer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, both strobes are low and no countdown is pending.
- R2: A sync event is `pin_sync_i` or `sw_sync_i` high at a rising edge. An event accepted with hold-off N (N >= 2) makes `update_o` high for exactly one cycle, N-1 rising edges after the edge that captured the event.
- R3: An event accepted with hold-off 1 makes `update_o` high in the cycle right after the capturing edge.
- R4: An event taken with hold-off 0 produces no update, and it cancels any countdown in progress.
- R5: An event accepted while a countdown is running reloads the counter from `holdoff_i`. The earlier countdown then produces no strobe.
- R6: `init_o` is high only together with `update_o`, and only when `init_on_sync_i` was high at the edge that issued the update.
- R7: When `first_only_i` is high, only the first event with a nonzero hold-off is accepted. Every later event is ignored and gives no update.
- R8: A one-cycle pulse on `first_only_wr_i` clears the first-only latch, so the next event is accepted again. Reset also clears the latch.
- R9: `sync_now_i` high at an edge makes `update_o` high in the next cycle, whatever the hold-off, the sync inputs and the first-only state are.
- R10: Both strobes are registered. One issued sync gives a strobe exactly one cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low reset |
| pin_sync_i | input | 1 | Sync from a device pin |
| sw_sync_i | input | 1 | Sync issued by software |
| holdoff_i | input | CNT_W (16) | Hold-off delay in clocks; 0 disables, 1 is immediate |
| sync_now_i | input | 1 | Force an update at once |
| init_on_sync_i | input | 1 | Attach an initialize strobe to each update |
| first_only_i | input | 1 | Honour only the first sync event |
| first_only_wr_i | input | 1 | Pulse when the first-only setting is rewritten; re-arms it |
| update_o | output | 1 | One-cycle update strobe to the gain loop |
| init_o | output | 1 | One-cycle initialize strobe to the gain loop |

## Verification
The bench checks the exact cycle of the strobe for hold-off values 1, 2 and 7. A counter that fires at 0 instead of 1, or that is off by one, shows up as a strobe one cycle early or late. It retriggers a countdown partway through and then checks two things: that there is no strobe at the original deadline, and that there is a strobe at the new one. A design that does not reload would fire early, or would fire twice. The bench also checks that a zero hold-off both stays silent and kills a pending countdown, that first-only blocks a second event until the rewrite strobe re-arms it, and that sync-now fires even with hold-off zero while first-only is blocking. These checks catch a latch that never clears and a sync-now that is gated by the sync path.

// File: rtl/gain_sync_timer.sv
module gain_sync_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_sync_i,
  input  logic             sw_sync_i,
  input  logic [CNT_W-1:0] holdoff_i,
  input  logic             sync_now_i,
  input  logic             init_on_sync_i,
  input  logic             first_only_i,
  input  logic             first_only_wr_i,
  output logic             update_o,
  output logic             init_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

  logic [CNT_W-1:0] cnt_q;
  logic             spent_q;
  logic             evt_raw, evt_ok, hold_zero, fire;

  assign evt_raw   = pin_sync_i | sw_sync_i;
  assign evt_ok    = evt_raw & ~(first_only_i & spent_q);
  assign hold_zero = (holdoff_i == '0);
  assign fire      = sync_now_i
                   | (evt_ok & (holdoff_i == ONE))
                   | (~evt_ok & (cnt_q == TWO));

  // counter holds 0 when idle; a stored 1 never occurs, the 2->1 step fires
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (evt_ok)         cnt_q <= (holdoff_i > ONE) ? holdoff_i : '0;
    else if (cnt_q == TWO)   cnt_q <= '0;
    else if (cnt_q != '0)    cnt_q <= cnt_q - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               spent_q <= 1'b0;
    else if (first_only_wr_i) spent_q <= 1'b0;
    else if (evt_ok && first_only_i && !hold_zero) spent_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      update_o <= 1'b0;
      init_o   <= 1'b0;
    end else begin
      update_o <= fire;
      init_o   <= fire & init_on_sync_i;
    end
  end

  a_r3_immediate: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_ok && holdoff_i == ONE) |=> update_o);

  a_r4_zero_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_ok && hold_zero && !sync_now_i) |=> (!update_o && cnt_q == '0));

  a_r6_init_with_update: assert property (@(posedge clk) disable iff (!rst_n)
    init_o |-> update_o);

  a_r6_init_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !init_on_sync_i |=> !init_o);

  a_r7_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_raw && first_only_i && spent_q && !sync_now_i && cnt_q == '0) |=> !update_o);

  a_r9_sync_now: assert property (@(posedge clk) disable iff (!rst_n)
    sync_now_i |=> update_o);

  a_r2_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_ok && cnt_q > TWO) |=> (cnt_q == $past(cnt_q) - ONE));
endmodule

// File: tb/gain_sync_timer_bench.sv
module gain_sync_timer_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic pin_sync = 0, sw_sync = 0, sync_now = 0, init_on = 0, first_only = 0, fo_wr = 0;
  logic [15:0] holdoff = 16'd0;
  logic update, init;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  gain_sync_timer u_gain_sync_timer (
    .clk(clk), .rst_n(rst_n), .pin_sync_i(pin_sync), .sw_sync_i(sw_sync),
    .holdoff_i(holdoff), .sync_now_i(sync_now), .init_on_sync_i(init_on),
    .first_only_i(first_only), .first_only_wr_i(fo_wr),
    .update_o(update), .init_o(init));

  task automatic check(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // event captured at next edge; returns at the negedge after that edge (k=0)
  task automatic fire_evt(bit use_sw);
    @(negedge clk);
    if (use_sw) sw_sync = 1; else pin_sync = 1;
    @(negedge clk);
    pin_sync = 0; sw_sync = 0;
  endtask

  task automatic t_reset;
    check("R1 update in reset", update, 1'b0);
    check("R1 init in reset", init, 1'b0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    check("R1 update after reset", update, 1'b0);
    check("R1 init after reset", init, 1'b0);
  endtask

  task automatic t_hold(int n, bit use_sw, bit ini);
    holdoff = 16'(n); init_on = ini;
    fire_evt(use_sw);
    for (int k = 0; k <= n + 1; k++) begin
      if (k > 0) @(negedge clk);
      check(n == 1 ? "R3 immediate" : "R2 hold-off timing", update, k == n - 1);
      check("R6 init follows bit", init, (k == n - 1) && ini);
    end
    check("R10 single cycle", update, 1'b0);
  endtask

  task automatic t_zero;
    holdoff = 16'd0;
    fire_evt(0);
    for (int k = 0; k < 6; k++) begin
      check("R4 zero no sync", update, 1'b0);
      @(negedge clk);
    end
    holdoff = 16'd4;
    fire_evt(0);
    @(negedge clk);
    holdoff = 16'd0; pin_sync = 1;
    @(negedge clk);
    pin_sync = 0;
    for (int k = 0; k < 6; k++) begin
      check("R4 zero cancels", update, 1'b0);
      @(negedge clk);
    end
  endtask

  task automatic t_restart;
    holdoff = 16'd5;
    fire_evt(1);
    for (int k = 1; k <= 9; k++) begin
      @(negedge clk);
      check("R5 restart", update, k == 7);
      if (k == 2) pin_sync = 1;
      if (k == 3) pin_sync = 0;
    end
  endtask

  task automatic t_first_only;
    first_only = 1; holdoff = 16'd3; init_on = 0;
    fire_evt(0);
    @(negedge clk); @(negedge clk);
    check("R7 first accepted", update, 1'b1);
    fire_evt(0);
    for (int k = 0; k < 5; k++) begin
      check("R7 later ignored", update, 1'b0);
      @(negedge clk);
    end
    sync_now = 1; holdoff = 16'd0;
    @(negedge clk);
    sync_now = 0;
    check("R9 sync now while blocked", update, 1'b1);
    holdoff = 16'd3;
    @(negedge clk);
    fo_wr = 1;
    @(negedge clk);
    fo_wr = 0;
    fire_evt(1);
    @(negedge clk); @(negedge clk);
    check("R8 rearmed", update, 1'b1);
    first_only = 0;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic t_sync_now;
    holdoff = 16'd0; init_on = 1;
    @(negedge clk);
    sync_now = 1;
    @(negedge clk);
    sync_now = 0;
    check("R9 sync now update", update, 1'b1);
    check("R6 sync now init", init, 1'b1);
    @(negedge clk);
    check("R10 strobe ends", update, 1'b0);
    init_on = 0;
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_hold(1, 0, 1);
        t_hold(2, 1, 0);
        t_hold(7, 0, 1);
        t_zero();
        t_restart();
        t_first_only();
        t_sync_now();
      end
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule